// File: doc/BRIEF.md
# Sync Word Correlator with Bit-Error Tolerance

This block watches a recovered serial bit stream for a programmable sync word. Each rising edge of the recovered bit clock shifts one received bit into a history register. The most recent window of received bits is then compared against the leading bytes of a 32-bit pattern. The window holds 1, 2, 3 or 4 whole bytes.

The block counts the bit positions where the window and the pattern differ. If that count is within a programmable tolerance of 0 to 3 errors, a registered match flag is raised for that bit period. A detect-enable input gates the flag. The shift register keeps running while detection is off, so turning detection on again needs no refill delay. Framing of the payload that follows the sync word is left to downstream logic.

Top module: `sync_correlator`

## Requirements
- R1: While `rstN` is low, `matchOut` is 0.
- R2: Received bits enter MSB-first. `matchOut` is a register clocked by the rising edge of `bitClk`. It reflects the window that includes the bit sampled at that same edge, so it rises at the edge that samples the final sync bit, and not one bit earlier.
- R3: `sizeSel` code k (0..3) selects n = k+1 bytes. The last 8n received bits are compared against `pattern[31 -: 8n]`, and the first bit sent lines up with `pattern[31]`.
- R4: Pattern bits below the selected bytes, and received bits older than the last 8n, have no effect on `matchOut`.
- R5: With `tolSel` code t (0..3), `matchOut` is 1 when the number of differing bits is t or fewer.
- R6: When the number of differing bits exceeds t, `matchOut` is 0.
- R7: If `enable` is 0 at a rising edge of `bitClk`, `matchOut` is 0 after that edge.
- R8: A match asserts `matchOut` for exactly one bit period. It stays high at the next edge only if the newly shifted window also matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Recovered bit clock; active on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 1 | Recovered data bit |
| pattern | input | 32 | Sync word, left-aligned (first bit in bit 31) |
| sizeSel | input | 2 | Sync length code: 0..3 selects 1..4 bytes |
| tolSel | input | 2 | Allowed bit errors, 0..3 |
| enable | input | 1 | Detection enable |
| matchOut | output | 1 | Match flag, synchronous to `bitClk` |

## Verification
The bench checks the flag one bit before and exactly at the final sync bit. A flag registered one stage late, or one that compares the window from before the new bit, fails there. Each size code is run with garbage in the unused low pattern bytes and in older received bits. A wrong mask or a wrong alignment shift then shows up as a missed or a spurious match. The tolerance is tested just below and just above its limit: an off-by-one in the threshold matches one error too many or too few. Runs of repeated and alternating bits check that the flag drops after one period unless the shifted window still matches. A sticky flag would stay high in those runs.

// File: rtl/sync_corr_pkg.sv
package sync_corr_pkg;
  parameter int SYNC_BYTES = 4;
  parameter int BYTE_W     = 8;
  parameter int SIZE_W     = 2;
  parameter int TOL_W      = 2;
  localparam int PAT_W     = SYNC_BYTES * BYTE_W;
  localparam int SHIFT_W   = $clog2(PAT_W);
  localparam int CNT_W     = $clog2(PAT_W + 1);

  typedef struct packed {
    logic               detectEn;
    logic [PAT_W-1:0]   cmpMask;
    logic [SHIFT_W-1:0] alignShift;
    logic [TOL_W-1:0]   errLimit;
  } ctl_strobe_t;
endpackage

// File: rtl/sync_corr_ctrl.sv
module sync_corr_ctrl
  import sync_corr_pkg::*;
(
  input  logic              enable,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic [TOL_W-1:0]  tolSel,
  output ctl_strobe_t       strobe
);
  localparam int LAST_BYTE = SYNC_BYTES - 1;

  logic [PAT_W-1:0]   maskBytes;
  logic [SHIFT_W-1:0] shiftAmt;

  // Low bytes of the mask are active up to the selected length
  for (genvar b = 0; b < SYNC_BYTES; b++) begin : g_mask
    assign maskBytes[b*BYTE_W +: BYTE_W] =
      (SIZE_W'(b) <= sizeSel) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
  end

  // Leading pattern bytes are moved down to the window's position
  always_comb begin
    shiftAmt = SHIFT_W'((LAST_BYTE - int'(sizeSel)) * BYTE_W);
  end

  assign strobe.detectEn   = enable;
  assign strobe.cmpMask    = maskBytes;
  assign strobe.alignShift = shiftAmt;
  assign strobe.errLimit   = tolSel;
endmodule

// File: rtl/sync_corr_dpath.sv
module sync_corr_dpath
  import sync_corr_pkg::*;
(
  input  logic             bitClk,
  input  logic             rstN,
  input  logic             dataIn,
  input  logic [PAT_W-1:0] pattern,
  input  ctl_strobe_t      strobe,
  output logic             matchOut
);
  logic [PAT_W-1:0] shReg;
  logic [PAT_W-1:0] shNext;
  logic [PAT_W-1:0] patAligned;
  logic [PAT_W-1:0] diffBits;
  logic [CNT_W-1:0] errCnt;
  logic             hit;

  assign shNext     = {shReg[PAT_W-2:0], dataIn};
  assign patAligned = pattern >> strobe.alignShift;
  assign diffBits   = (shNext ^ patAligned) & strobe.cmpMask;

  always_comb begin
    errCnt = '0;
    for (int i = 0; i < PAT_W; i++) begin
      errCnt = errCnt + CNT_W'(diffBits[i]);
    end
  end

  assign hit = (errCnt <= CNT_W'(strobe.errLimit));

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      matchOut <= 1'b0;
    end else begin
      shReg    <= shNext;
      matchOut <= strobe.detectEn & hit;
    end
  end

  AST_RESET_LOW: assert property (@(posedge bitClk) !rstN |-> !matchOut); // R1
  AST_MSB_FIRST_SHIFT: assert property (@(posedge bitClk) disable iff (!rstN)
    1'b1 |=> shReg[0] == $past(dataIn)); // R2
  AST_WITHIN_TOL: assert property (@(posedge bitClk) disable iff (!rstN)
    (strobe.detectEn && errCnt <= CNT_W'(strobe.errLimit)) |=> matchOut); // R5
  AST_OVER_TOL: assert property (@(posedge bitClk) disable iff (!rstN)
    (errCnt > CNT_W'(strobe.errLimit)) |=> !matchOut); // R6
  AST_DISABLED_LOW: assert property (@(posedge bitClk) disable iff (!rstN)
    !strobe.detectEn |=> !matchOut); // R7
endmodule

// File: rtl/sync_correlator.sv
module sync_correlator
  import sync_corr_pkg::*;
(
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              dataIn,
  input  logic [PAT_W-1:0]  pattern,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic [TOL_W-1:0]  tolSel,
  input  logic              enable,
  output logic              matchOut
);
  ctl_strobe_t strobe;

  sync_corr_ctrl u_ctrl (
    .enable  (enable),
    .sizeSel (sizeSel),
    .tolSel  (tolSel),
    .strobe  (strobe)
  );

  sync_corr_dpath u_dpath (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .pattern  (pattern),
    .strobe   (strobe),
    .matchOut (matchOut)
  );
endmodule

// File: tb/sync_correlator_tb.sv
module sync_correlator_tb;
  logic        bitClk = 1'b0;
  logic        rstN;
  logic        dataIn;
  logic [31:0] pattern;
  logic [1:0]  sizeSel;
  logic [1:0]  tolSel;
  logic        enable;
  logic        matchOut;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  sync_correlator u_dut (
    .bitClk(bitClk), .rstN(rstN), .dataIn(dataIn), .pattern(pattern),
    .sizeSel(sizeSel), .tolSel(tolSel), .enable(enable), .matchOut(matchOut)
  );

  always #2.5 bitClk = ~bitClk;

  task automatic check(input logic exp, input string req);
    total++;
    if (matchOut !== exp) begin
      bad++;
      $display("FAIL %s: matchOut=%b expected=%b at %0t", req, matchOut, exp, $time);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge bitClk);
    dataIn = b;
    @(posedge bitClk);
    #1;
  endtask

  task automatic sendWord(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic configure(input logic [31:0] p, input logic [1:0] s,
                           input logic [1:0] t, input logic en);
    @(negedge bitClk);
    pattern = p; sizeSel = s; tolSel = t; enable = en;
  endtask

  task automatic testReset();
    rstN = 1'b0; dataIn = 1'b0; pattern = '0; sizeSel = 2'd3;
    tolSel = 2'd0; enable = 1'b1;
    repeat (3) @(posedge bitClk);
    #1 check(1'b0, "R1 flag low in reset");
    @(negedge bitClk) rstN = 1'b1;
  endtask

  task automatic testFourByte();
    configure(32'hB5C3_9A17, 2'd3, 2'd0, 1'b1);
    sendWord(32'h0000_AAAA, 16);
    sendWord(32'hB5C3_9A17 >> 1, 31);
    check(1'b0, "R2 no flag before last bit");
    sendBit(1'b1);
    check(1'b1, "R2 R3 four-byte match at last bit");
    sendBit(1'b0);
    check(1'b0, "R8 drops after one period");
  endtask

  task automatic testOneByte();
    configure(32'hA7_3C_E1_55, 2'd0, 2'd0, 1'b1);
    sendWord(32'h0000_1234, 16);
    sendWord(32'h0000_0000, 8);
    sendWord(32'h0000_0053, 7);
    check(1'b0, "R3 one-byte no early flag");
    sendBit(1'b1);
    check(1'b1, "R3 R4 one-byte match ignores low pattern bytes and old bits");
  endtask

  task automatic testThreeByte();
    configure(32'h6E_91_C4_FF, 2'd2, 2'd0, 1'b1);
    sendWord(32'h0000_00F0, 8);
    sendWord(32'h006E_91C4, 24);
    check(1'b1, "R3 R4 three-byte match");
  endtask

  task automatic testTolerance();
    configure(32'h2DD4_0000, 2'd1, 2'd2, 1'b1);
    sendWord(32'h0000_ADD5, 16);
    check(1'b1, "R5 two errors within tol 2");
    configure(32'h2DD4_0000, 2'd1, 2'd1, 1'b1);
    sendWord(32'h0000_ADD5, 16);
    check(1'b0, "R6 two errors over tol 1");
    configure(32'h2DD4_0000, 2'd1, 2'd3, 1'b1);
    sendWord(32'h0000_ADD7, 16);
    check(1'b1, "R5 three errors within tol 3");
    sendWord(32'h0000_AD57, 16);
    check(1'b0, "R6 four errors over tol 3");
  endtask

  task automatic testEnable();
    configure(32'hA7_00_00_00, 2'd0, 2'd0, 1'b0);
    sendWord(32'h0000_00A7, 8);
    check(1'b0, "R7 disabled no flag");
    configure(32'hA7_00_00_00, 2'd0, 2'd0, 1'b1);
    sendWord(32'h0000_00A7, 8);
    check(1'b1, "R7 re-enabled match without refill");
  endtask

  task automatic testRepeat();
    configure(32'hFF_00_00_00, 2'd0, 2'd0, 1'b1);
    sendWord(32'h0000_0000, 8);
    sendWord(32'h0000_00FF, 8);
    check(1'b1, "R8 ones window matches");
    sendBit(1'b1);
    check(1'b1, "R8 stays high when next window matches");
    sendBit(1'b0);
    check(1'b0, "R8 falls when window breaks");
    configure(32'hAA_00_00_00, 2'd0, 2'd0, 1'b1);
    sendWord(32'h0000_00AA, 8);
    check(1'b1, "R8 alternating match");
    sendBit(1'b1);
    check(1'b0, "R8 single period on alternating stream");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    testReset();
    testFourByte();
    testOneByte();
    testThreeByte();
    testTolerance();
    testEnable();
    testRepeat();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule